// File: doc/BRIEF.md
# Offset and Gain Calibration Engine

This block is the digital half of a foreground trim loop for a two-channel time-interleaved 8-bit converter. A start pulse begins the sequence. The engine first steers the analog input selector to a grounded input. Each sub-converter should then sit halfway between codes 127 and 128. For every sample, the engine takes the signed distance from that midpoint and sums it over a power-of-two window. It shifts the sum down to get a mean and nudges that channel's offset trim one step against the sign of the mean. The two channels are handled side by side, each with its own sum and its own trim.

When both offset loops have settled, the selector moves to a fixed DC reference. The same loop then runs against a programmable expected code and drives the gain trims. A channel is settled, and its trim frozen, once its mean error stays inside a small band for two iterations in a row. The run ends with a done flag. It also ends, with an error flag raised, if a phase uses up its iteration budget before both channels settle.

All error arithmetic is done in half-LSB units: the code is doubled and 255 is subtracted (offset phase), or twice the reference code is subtracted (gain phase). This makes the 127.5 target an integer.

Top module: `ofsgain_cal`

States: `ST_IDLE`, `ST_OFS_SETTLE`, `ST_OFS_ACC`, `ST_OFS_UPD`, `ST_OFS_CHK`, `ST_GAIN_SETTLE`, `ST_GAIN_ACC`, `ST_GAIN_UPD`, `ST_GAIN_CHK`, `ST_DONE`, `ST_FAIL`.

Transitions:

- **idle-start:** `ST_IDLE` to `ST_OFS_SETTLE` on `start`.
- **settle-filled:** `*_SETTLE` to `*_ACC` after SETTLE valid samples.
- **window-filled:** `*_ACC` to `*_UPD` on the last valid sample of the window.
- **update-done:** `*_UPD` to `*_CHK`, always.
- **ofs-locked:** `ST_OFS_CHK` to `ST_GAIN_SETTLE` when both offset loops are locked.
- **gain-locked:** `ST_GAIN_CHK` to `ST_DONE` when both gain loops are locked.
- **retry:** `*_CHK` back to `*_SETTLE` otherwise.
- **budget-out:** `*_CHK` to `ST_FAIL` when MAX_ITER updates were made in the phase without both channels locked.
- **restart:** `ST_DONE`/`ST_FAIL` to `ST_OFS_SETTLE` on `start`.

## Requirements
- R1: After reset all four trims read 128, `phase` is 0 (idle), `in_sel` is 2'b00 (signal input), and `done` and `cal_err` are low.
- R2: A `start` seen in idle, done or fail reloads all four trims to 128 and clears the flags at that edge. From the next cycle `phase` is 1 (offset) and `in_sel` is 2'b01 (grounded input).
- R3: In the offset phase each counted sample contributes 2*code-255. The sum over 2^N samples (N = `acc_log2`, limited to MAX_LOG2) is shifted right arithmetically by N to form the mean error.
- R4: In the gain phase each counted sample contributes 2*code-2*`gain_ref`. The mean is formed the same way.
- R5: At each update of an unlocked channel whose mean is outside [-THRESH, THRESH], the trim moves by exactly one, down for a positive mean and up for a negative one, and stays within 0..255. Inside the band the trim holds.
- R6: Two consecutive in-band updates lock a channel. A locked trim does not change for the rest of the phase.
- R7: The gain phase (`phase` 2, `in_sel` 2'b10) is entered only from the offset phase after both offset loops lock. Offset trims stay constant throughout the gain phase.
- R8: When both gain loops lock, `phase` goes to 3, `done` rises with `cal_err` low, and `in_sel` returns to 2'b00. This holds until the next start.
- R9: If MAX_ITER (default 255) updates happen in one phase without both channels locked, `phase` goes to 3 with `done` and `cal_err` both high and `in_sel` 2'b00.
- R10: Only cycles with `smp_valid` high count as samples. After phase entry and after every update, the first SETTLE (default 4) valid samples are discarded. A sample arriving in the update or check cycle is ignored.
- R11: The two channels are estimated and trimmed independently. Each channel's final trims depend only on its own codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (accepted when not busy) |
| smp_valid | input | 1 | Both channel codes are valid this cycle |
| code_a | input | 8 | Output code of sub-converter A |
| code_b | input | 8 | Output code of sub-converter B |
| gain_ref | input | 8 | Expected code for the DC reference in the gain phase |
| acc_log2 | input | 4 | Log2 of the averaging window length |
| in_sel | output | 2 | Input selector: 00 signal, 01 ground, 10 DC reference |
| phase | output | 2 | 0 idle, 1 offset, 2 gain, 3 finished |
| ofs_trim_a | output | 8 | Offset trim code, channel A |
| ofs_trim_b | output | 8 | Offset trim code, channel B |
| gain_trim_a | output | 8 | Gain trim code, channel A |
| gain_trim_b | output | 8 | Gain trim code, channel B |
| done | output | 1 | Run finished |
| cal_err | output | 1 | Run ended on the iteration budget |

## Verification
A wrong accumulator, a bad shift or a broken settle discard shows up at the ports as trims that lock one or more steps away from the closed-form target the bench derives from each channel's injected error. This becomes visible at the first phase boundary, as soon as `phase` moves on. A lock flag that sets too early or never sets shows up as a wrong offset trim at gain entry, or as `cal_err` after the iteration budget. A sequencing fault is caught within one cycle by the selector and phase relations in the checker. The bench closes the loop with a behavioural converter model that emits junk codes right after every trim or selector change, so a skipped discard corrupts the mean within that same iteration.

// File: rtl/ofsgain_cal_pkg.sv
package ofsgain_cal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFS_SETTLE,
        ST_OFS_ACC,
        ST_OFS_UPD,
        ST_OFS_CHK,
        ST_GAIN_SETTLE,
        ST_GAIN_ACC,
        ST_GAIN_UPD,
        ST_GAIN_CHK,
        ST_DONE,
        ST_FAIL
    } cal_state_e;

    typedef enum logic [1:0] {
        SEL_SIGNAL = 2'b00,
        SEL_ZERO   = 2'b01,
        SEL_GREF   = 2'b10
    } in_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OFS  = 2'd1,
        PH_GAIN = 2'd2,
        PH_END  = 2'd3
    } phase_e;

endpackage

// File: rtl/ofsgain_cal_acc.sv
// Per-channel error accumulator: doubles the code, removes the doubled
// target, sums over the window and yields the arithmetic-shift mean.
module ofsgain_cal_acc #(
    parameter int CODE_W   = 8,
    parameter int MAX_LOG2 = 8,
    parameter int SH_W     = 4,
    parameter int ACC_W    = CODE_W + 2 + MAX_LOG2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    tgt_gain,
    input  logic [CODE_W-1:0]       code,
    input  logic [CODE_W-1:0]       gain_ref,
    input  logic [SH_W-1:0]         n_eff,
    output logic signed [ACC_W-1:0] avg
);
    localparam int ERR_W = CODE_W + 2;
    // doubled midscale target: 2*(2^(CODE_W-1)) - 1, e.g. 255 for 8 bits
    localparam logic [ERR_W-1:0] MID2 = ERR_W'((1 << CODE_W) - 1);

    logic [ERR_W-1:0]        tgt2;
    logic [ERR_W-1:0]        code2;
    logic signed [ERR_W-1:0] err;
    logic signed [ACC_W-1:0] err_ext;
    logic signed [ACC_W-1:0] acc_q;

    always_comb begin
        code2   = {1'b0, code, 1'b0};
        tgt2    = tgt_gain ? {1'b0, gain_ref, 1'b0} : MID2;
        err     = signed'(code2 - tgt2);
        err_ext = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
        avg     = acc_q >>> n_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_q + err_ext;
        end
    end

endmodule

// File: rtl/ofsgain_cal_trim.sv
// One trim loop: unit step against the mean's sign, saturating, with a
// two-in-a-row in-band lock.
module ofsgain_cal_trim #(
    parameter int TRIM_W = 8,
    parameter int ACC_W  = 18,
    parameter int THRESH = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_mid,
    input  logic                    upd,
    input  logic signed [ACC_W-1:0] avg,
    output logic [TRIM_W-1:0]       trim,
    output logic                    locked
);
    localparam logic [TRIM_W-1:0]       MID  = TRIM_W'(1 << (TRIM_W - 1));
    localparam logic [TRIM_W-1:0]       TOP  = {TRIM_W{1'b1}};
    localparam logic signed [ACC_W-1:0] TH_P = ACC_W'(THRESH);
    localparam logic signed [ACC_W-1:0] TH_N = -TH_P;

    logic in_band;
    logic half_q;
    logic [TRIM_W-1:0] trim_q;
    logic locked_q;

    assign in_band = (avg <= TH_P) && (avg >= TH_N);
    assign trim    = trim_q;
    assign locked  = locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_q   <= MID;
            half_q   <= 1'b0;
            locked_q <= 1'b0;
        end else if (ld_mid) begin
            trim_q   <= MID;
            half_q   <= 1'b0;
            locked_q <= 1'b0;
        end else if (upd && !locked_q) begin
            if (in_band) begin
                if (half_q) begin
                    locked_q <= 1'b1;
                end
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                if (avg > 0) begin
                    if (trim_q != '0) begin
                        trim_q <= trim_q - 1'b1;
                    end
                end else begin
                    if (trim_q != TOP) begin
                        trim_q <= trim_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ofsgain_cal_seq.sv
// Phase sequencer: settle, accumulate, update, check for each phase.
module ofsgain_cal_seq
    import ofsgain_cal_pkg::*;
#(
    parameter int MAX_LOG2 = 8,
    parameter int SH_W     = 4,
    parameter int SETTLE   = 4,
    parameter int MAX_ITER = 255
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            smp_valid,
    input  logic [SH_W-1:0] n_eff,
    input  logic            ofs_locked,
    input  logic            gain_locked,
    output logic            acc_clr,
    output logic            acc_en,
    output logic            tgt_gain,
    output logic            ld_mid,
    output logic            upd_ofs,
    output logic            upd_gain,
    output logic [1:0]      in_sel,
    output logic [1:0]      phase,
    output logic            done,
    output logic            cal_err
);
    localparam int SET_BITS = $clog2(SETTLE + 1);
    localparam int CNT_W    = (SET_BITS > MAX_LOG2 + 1) ? SET_BITS : MAX_LOG2 + 1;
    localparam int ITER_W   = $clog2(MAX_ITER + 1);
    localparam logic [CNT_W-1:0]  SET_LAST = CNT_W'(SETTLE - 1);
    localparam logic [ITER_W-1:0] ITER_CAP = ITER_W'(MAX_ITER);

    cal_state_e state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ITER_W-1:0] iter_q;
    logic [CNT_W-1:0]  win_last;
    logic              settle_st, acc_st, upd_st;

    assign win_last  = (CNT_W'(1) << n_eff) - CNT_W'(1);
    assign settle_st = (state_q == ST_OFS_SETTLE) || (state_q == ST_GAIN_SETTLE);
    assign acc_st    = (state_q == ST_OFS_ACC) || (state_q == ST_GAIN_ACC);
    assign upd_st    = (state_q == ST_OFS_UPD) || (state_q == ST_GAIN_UPD);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) state_d = ST_OFS_SETTLE;
            end
            ST_OFS_SETTLE: begin
                if (smp_valid && cnt_q == SET_LAST) state_d = ST_OFS_ACC;
            end
            ST_OFS_ACC: begin
                if (smp_valid && cnt_q == win_last) state_d = ST_OFS_UPD;
            end
            ST_OFS_UPD: state_d = ST_OFS_CHK;
            ST_OFS_CHK: begin
                if (ofs_locked)             state_d = ST_GAIN_SETTLE;
                else if (iter_q >= ITER_CAP) state_d = ST_FAIL;
                else                        state_d = ST_OFS_SETTLE;
            end
            ST_GAIN_SETTLE: begin
                if (smp_valid && cnt_q == SET_LAST) state_d = ST_GAIN_ACC;
            end
            ST_GAIN_ACC: begin
                if (smp_valid && cnt_q == win_last) state_d = ST_GAIN_UPD;
            end
            ST_GAIN_UPD: state_d = ST_GAIN_CHK;
            ST_GAIN_CHK: begin
                if (gain_locked)             state_d = ST_DONE;
                else if (iter_q >= ITER_CAP) state_d = ST_FAIL;
                else                         state_d = ST_GAIN_SETTLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sample and iteration counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            iter_q <= '0;
        end else begin
            if (state_d != state_q)                 cnt_q <= '0;
            else if (smp_valid && (settle_st || acc_st)) cnt_q <= cnt_q + 1'b1;

            if (ld_mid || (state_q == ST_OFS_CHK && state_d == ST_GAIN_SETTLE))
                iter_q <= '0;
            else if (upd_st)
                iter_q <= iter_q + 1'b1;
        end
    end

    // output decode
    always_comb begin
        acc_clr  = settle_st;
        acc_en   = acc_st && smp_valid;
        tgt_gain = 1'b0;
        ld_mid   = 1'b0;
        upd_ofs  = 1'b0;
        upd_gain = 1'b0;
        in_sel   = SEL_SIGNAL;
        phase    = PH_IDLE;
        done     = 1'b0;
        cal_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ld_mid = start;
            end
            ST_OFS_SETTLE, ST_OFS_ACC, ST_OFS_CHK: begin
                in_sel = SEL_ZERO;
                phase  = PH_OFS;
            end
            ST_OFS_UPD: begin
                in_sel  = SEL_ZERO;
                phase   = PH_OFS;
                upd_ofs = 1'b1;
            end
            ST_GAIN_SETTLE, ST_GAIN_ACC, ST_GAIN_CHK: begin
                in_sel   = SEL_GREF;
                phase    = PH_GAIN;
                tgt_gain = 1'b1;
            end
            ST_GAIN_UPD: begin
                in_sel   = SEL_GREF;
                phase    = PH_GAIN;
                tgt_gain = 1'b1;
                upd_gain = 1'b1;
            end
            ST_DONE: begin
                phase  = PH_END;
                done   = 1'b1;
                ld_mid = start;
            end
            ST_FAIL: begin
                phase   = PH_END;
                done    = 1'b1;
                cal_err = 1'b1;
                ld_mid  = start;
            end
            default: begin
                phase = PH_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/ofsgain_cal.sv
module ofsgain_cal
    import ofsgain_cal_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int TRIM_W   = 8,
    parameter int MAX_LOG2 = 8,
    parameter int SETTLE   = 4,
    parameter int MAX_ITER = 255,
    parameter int THRESH   = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          smp_valid,
    input  logic [CODE_W-1:0]             code_a,
    input  logic [CODE_W-1:0]             code_b,
    input  logic [CODE_W-1:0]             gain_ref,
    input  logic [$clog2(MAX_LOG2+1)-1:0] acc_log2,
    output logic [1:0]                    in_sel,
    output logic [1:0]                    phase,
    output logic [TRIM_W-1:0]             ofs_trim_a,
    output logic [TRIM_W-1:0]             ofs_trim_b,
    output logic [TRIM_W-1:0]             gain_trim_a,
    output logic [TRIM_W-1:0]             gain_trim_b,
    output logic                          done,
    output logic                          cal_err
);
    localparam int NCH   = 2;
    localparam int SH_W  = $clog2(MAX_LOG2 + 1);
    localparam int ACC_W = CODE_W + 2 + MAX_LOG2;

    logic [SH_W-1:0]         n_eff;
    logic                    acc_clr, acc_en, tgt_gain, ld_mid, upd_ofs, upd_gain;
    logic [CODE_W-1:0]       code_arr  [NCH];
    logic signed [ACC_W-1:0] avg_arr   [NCH];
    logic [TRIM_W-1:0]       otrim_arr [NCH];
    logic [TRIM_W-1:0]       gtrim_arr [NCH];
    logic [NCH-1:0]          olock, glock;

    assign n_eff       = (acc_log2 > SH_W'(MAX_LOG2)) ? SH_W'(MAX_LOG2) : acc_log2;
    assign code_arr[0] = code_a;
    assign code_arr[1] = code_b;
    assign ofs_trim_a  = otrim_arr[0];
    assign ofs_trim_b  = otrim_arr[1];
    assign gain_trim_a = gtrim_arr[0];
    assign gain_trim_b = gtrim_arr[1];

    ofsgain_cal_seq #(
        .MAX_LOG2 (MAX_LOG2),
        .SH_W     (SH_W),
        .SETTLE   (SETTLE),
        .MAX_ITER (MAX_ITER)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .smp_valid   (smp_valid),
        .n_eff       (n_eff),
        .ofs_locked  (&olock),
        .gain_locked (&glock),
        .acc_clr     (acc_clr),
        .acc_en      (acc_en),
        .tgt_gain    (tgt_gain),
        .ld_mid      (ld_mid),
        .upd_ofs     (upd_ofs),
        .upd_gain    (upd_gain),
        .in_sel      (in_sel),
        .phase       (phase),
        .done        (done),
        .cal_err     (cal_err)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ofsgain_cal_acc #(
            .CODE_W   (CODE_W),
            .MAX_LOG2 (MAX_LOG2),
            .SH_W     (SH_W),
            .ACC_W    (ACC_W)
        ) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (acc_clr),
            .en       (acc_en),
            .tgt_gain (tgt_gain),
            .code     (code_arr[ch]),
            .gain_ref (gain_ref),
            .n_eff    (n_eff),
            .avg      (avg_arr[ch])
        );

        ofsgain_cal_trim #(
            .TRIM_W (TRIM_W),
            .ACC_W  (ACC_W),
            .THRESH (THRESH)
        ) u_ofs (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_mid (ld_mid),
            .upd    (upd_ofs),
            .avg    (avg_arr[ch]),
            .trim   (otrim_arr[ch]),
            .locked (olock[ch])
        );

        ofsgain_cal_trim #(
            .TRIM_W (TRIM_W),
            .ACC_W  (ACC_W),
            .THRESH (THRESH)
        ) u_gain (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_mid (ld_mid),
            .upd    (upd_gain),
            .avg    (avg_arr[ch]),
            .trim   (gtrim_arr[ch]),
            .locked (glock[ch])
        );
    end

endmodule

// File: rtl/ofsgain_cal_chk.sv
module ofsgain_cal_chk #(
    parameter int TRIM_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        in_sel,
    input logic [1:0]        phase,
    input logic [TRIM_W-1:0] ofs_trim_a,
    input logic [TRIM_W-1:0] ofs_trim_b,
    input logic [TRIM_W-1:0] gain_trim_a,
    input logic [TRIM_W-1:0] gain_trim_b,
    input logic              done,
    input logic              cal_err
);
    function automatic logic step_ok(logic [TRIM_W-1:0] now, logic [TRIM_W-1:0] was);
        return (now == was) || (now == was + 1'b1) || (was == now + 1'b1);
    endfunction

    // R2: grounded input whenever the offset phase is reported
    p_sel_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> (in_sel == 2'b01));

    // R5: trims move at most one code per cycle while a phase runs
    p_ofs_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 2'd1 || $past(phase) == 2'd2) |->
        (step_ok(ofs_trim_a, $past(ofs_trim_a)) && step_ok(ofs_trim_b, $past(ofs_trim_b))));

    p_gain_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 2'd1 || $past(phase) == 2'd2) |->
        (step_ok(gain_trim_a, $past(gain_trim_a)) && step_ok(gain_trim_b, $past(gain_trim_b))));

    // R7: gain phase only follows the offset phase
    p_gain_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && $past(phase) != 2'd2) |-> ($past(phase) == 2'd1));

    // R7: offset trims frozen during the gain phase
    p_ofs_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && $past(phase) == 2'd2) |->
        ($stable(ofs_trim_a) && $stable(ofs_trim_b)));

    // R7: reference input whenever the gain phase is reported
    p_sel_gain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |-> (in_sel == 2'b10));

    // R8: done only in the finished phase with the signal input selected
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == 2'd3 && in_sel == 2'b00));

    // R9: error flag only together with done
    p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |-> done);

endmodule

bind ofsgain_cal ofsgain_cal_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_sel      (in_sel),
    .phase       (phase),
    .ofs_trim_a  (ofs_trim_a),
    .ofs_trim_b  (ofs_trim_b),
    .gain_trim_a (gain_trim_a),
    .gain_trim_b (gain_trim_b),
    .done        (done),
    .cal_err     (cal_err)
);

// File: tb/ofsgain_cal_tb.sv
`timescale 1ns/1ps
module ofsgain_cal_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] code_a = '0, code_b = '0, gain_ref = '0;
    logic [3:0] acc_log2 = '0;
    logic [1:0] in_sel, phase;
    logic [7:0] ofs_trim_a, ofs_trim_b, gain_trim_a, gain_trim_b;
    logic       done, cal_err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // snapshots taken at phase entries
    int s1_sel, s1_oa, s1_ob, s1_ga, s1_gb, s1_err;
    int s2_sel, s2_oa, s2_ob;

    always #2.5 clk = ~clk;

    ofsgain_cal u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
        .code_a(code_a), .code_b(code_b), .gain_ref(gain_ref), .acc_log2(acc_log2),
        .in_sel(in_sel), .phase(phase), .ofs_trim_a(ofs_trim_a), .ofs_trim_b(ofs_trim_b),
        .gain_trim_a(gain_trim_a), .gain_trim_b(gain_trim_b), .done(done), .cal_err(cal_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // closed-form lock points derived from the requirements
    function automatic int exp_ofs(input int e);
        return (e > 0) ? 129 - e : 128 - e;
    endfunction
    function automatic int exp_gain(input int g);
        return 128 - g;
    endfunction

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    // Closed-loop run with a behavioural converter model. Junk codes follow
    // each trim or selector change for three valid samples.
    task automatic run_cal(input int oe_a, input int oe_b, input int ge_a, input int ge_b,
                           input int dith, input int gap, input bit stuck_a,
                           input int n, input int gref, output bit ok);
        int garb = 0;
        int dsgn = 1;
        int k = 0;
        bit fin = 0;
        bit seen1 = 0;
        bit seen2 = 0;
        logic [1:0] p_sel;
        logic [7:0] p_oa, p_ob, p_ga, p_gb;
        bit v;
        acc_log2 = 4'(n);
        gain_ref = 8'(gref);
        @(negedge clk);
        start = 1'b1;
        smp_valid = 1'b0;
        p_sel = in_sel; p_oa = ofs_trim_a; p_ob = ofs_trim_b; p_ga = gain_trim_a; p_gb = gain_trim_b;
        while (!fin && k < 40000) begin
            @(negedge clk);
            start = 1'b0;
            if (in_sel != p_sel || ofs_trim_a != p_oa || ofs_trim_b != p_ob ||
                gain_trim_a != p_ga || gain_trim_b != p_gb) garb = 3;
            p_sel = in_sel; p_oa = ofs_trim_a; p_ob = ofs_trim_b; p_ga = gain_trim_a; p_gb = gain_trim_b;
            if (phase == 2'd1 && !seen1) begin
                seen1 = 1; s1_sel = in_sel; s1_oa = ofs_trim_a; s1_ob = ofs_trim_b;
                s1_ga = gain_trim_a; s1_gb = gain_trim_b; s1_err = cal_err;
            end
            if (phase == 2'd2 && !seen2) begin
                seen2 = 1; s2_sel = in_sel; s2_oa = ofs_trim_a; s2_ob = ofs_trim_b;
            end
            if (done) begin
                fin = 1;
                smp_valid = 1'b0;
            end else begin
                v = !(gap != 0 && (k % gap) == gap - 1);
                smp_valid = v;
                if (v) begin
                    if (garb > 0) begin
                        code_a = 8'd255; code_b = 8'd255; garb = garb - 1;
                    end else if (in_sel == 2'b01) begin
                        code_a = stuck_a ? 8'd200 :
                                 8'(clamp8(127 + oe_a + int'(ofs_trim_a) - 128 + dsgn * dith));
                        code_b = 8'(clamp8(127 + oe_b + int'(ofs_trim_b) - 128 - dsgn * dith));
                    end else if (in_sel == 2'b10) begin
                        code_a = 8'(clamp8(gref + ge_a + int'(gain_trim_a) - 128 + dsgn * dith));
                        code_b = 8'(clamp8(gref + ge_b + int'(gain_trim_b) - 128 - dsgn * dith));
                    end else begin
                        code_a = 8'd0; code_b = 8'd0;
                    end
                    dsgn = -dsgn;
                end
            end
            k = k + 1;
        end
        ok = fin;
    endtask

    task automatic t_reset();
        chk("R1 reset ofs_trim_a", ofs_trim_a, 128);
        chk("R1 reset ofs_trim_b", ofs_trim_b, 128);
        chk("R1 reset gain_trim_a", gain_trim_a, 128);
        chk("R1 reset gain_trim_b", gain_trim_b, 128);
        chk("R1 reset phase", phase, 0);
        chk("R1 reset in_sel", in_sel, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset cal_err", cal_err, 0);
    endtask

    task automatic t_basic();
        bit ok;
        run_cal(5, -3, 2, -6, 0, 0, 0, 2, 100, ok);
        chk("R8 basic run finished", ok, 1);
        chk("R2 start sel grounded", s1_sel, 1);
        chk("R2 start ofs_trim_a mid", s1_oa, 128);
        chk("R2 start gain_trim_b mid", s1_gb, 128);
        chk("R7 gain entry sel reference", s2_sel, 2);
        chk("R3 R6 offset lock A", s2_oa, exp_ofs(5));
        chk("R3 R11 offset lock B", s2_ob, exp_ofs(-3));
        chk("R7 ofs_trim_a held to end", ofs_trim_a, exp_ofs(5));
        chk("R4 R5 gain lock A", gain_trim_a, exp_gain(2));
        chk("R4 R11 gain lock B", gain_trim_b, exp_gain(-6));
        chk("R8 done", done, 1);
        chk("R8 no error", cal_err, 0);
        chk("R8 phase finished", phase, 3);
        chk("R8 sel signal", in_sel, 0);
    endtask

    task automatic t_dither_gaps();
        bit ok;
        run_cal(-7, 1, 0, 3, 3, 3, 0, 3, 60, ok);
        chk("R10 dither run finished", ok, 1);
        chk("R3 R10 averaged offset A", ofs_trim_a, exp_ofs(-7));
        chk("R3 R10 averaged offset B", ofs_trim_b, exp_ofs(1));
        chk("R4 R10 averaged gain A", gain_trim_a, exp_gain(0));
        chk("R4 R10 averaged gain B", gain_trim_b, exp_gain(3));
        chk("R8 dither no error", cal_err, 0);
    endtask

    task automatic t_timeout();
        bit ok;
        run_cal(0, 2, 0, 0, 0, 0, 1, 0, 100, ok);
        chk("R9 stuck run finished", ok, 1);
        chk("R9 error flag", cal_err, 1);
        chk("R9 done with error", done, 1);
        chk("R9 phase finished", phase, 3);
        chk("R9 sel signal", in_sel, 0);
        chk("R5 saturated at zero A", ofs_trim_a, 0);
        chk("R11 healthy channel B", ofs_trim_b, exp_ofs(2));
        chk("R7 gain never entered A", gain_trim_a, 128);
    endtask

    task automatic t_restart();
        bit ok;
        run_cal(0, -1, -1, 1, 0, 0, 0, 1, 200, ok);
        chk("R2 restart run finished", ok, 1);
        chk("R2 restart ofs_trim_a reloaded", s1_oa, 128);
        chk("R2 restart error cleared", s1_err, 0);
        chk("R2 restart sel grounded", s1_sel, 1);
        chk("R6 restart offset A", ofs_trim_a, exp_ofs(0));
        chk("R6 restart offset B", ofs_trim_b, exp_ofs(-1));
        chk("R5 restart gain A", gain_trim_a, exp_gain(-1));
        chk("R5 restart gain B", gain_trim_b, exp_gain(1));
        chk("R8 restart no error", cal_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dither_gaps();
        t_timeout();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule